// File: doc/BRIEF.md
# Byte-Lane Masked Synchronous RAM with Address Hold

This block is a single-clock synchronous memory of 16-bit words split into two 8-bit lanes. The address, write data, write enable, read enable and a 2-bit lane mask are captured on a rising clock edge. The array is accessed on the next edge, and that same edge loads the registered read output. Each lane of the array is written only when the write enable and that lane's mask bit are both high. Lanes that are not written keep their stored byte.

When a read and a write reach the same word in the same access, the output is resolved lane by lane. A masked lane always returns the byte that was already stored. A written lane returns either the incoming byte or the previously stored byte, as chosen by the `RDW_MODE` parameter.

The address capture register has a hold input. While the hold input is high, the register keeps its current address and ignores the address bus, so a run of accesses can be steered to one word without driving the bus. The word count is a parameter, and the address width is derived from it.

Top module: `bytelane_ram`

## Requirements
- R1: Mask bit 1 governs byte [15:8] and mask bit 0 governs byte [7:0]. Writing 16'hABCD over a stored 16'hFFFF leaves 16'hABFF with mask 2'b10, 16'hFFCD with mask 2'b01, and 16'hABCD with mask 2'b11.
- R2: During a combined write and read, a lane whose mask bit is 0 outputs the byte stored before the access.
- R3: During a combined write and read, a lane whose mask bit is 1 outputs the incoming byte when `RDW_MODE` is RDW_NEW, and the previously stored byte when it is RDW_OLD.
- R4: While `addr_hold` is high at a clock edge, the address register keeps its value and the address bus is ignored, for as many cycles as the hold stays high.
- R5: An access with `wr_en` low changes no stored byte, whatever the mask.
- R6: When the read stage has `rd_en` low, `rd_data` keeps its previous value.
- R7: Inputs sampled at edge N act on the array at edge N+1. `rd_data` is unchanged after edge N and shows the result after edge N+1.
- R8: A synchronous high `rst` clears `rd_data` and the address register to zero.
- R9: A write with `wr_en` high and mask 2'b00 leaves the word unchanged, and a simultaneous read returns the old word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 9 | Word address (width is log2 of DEPTH) |
| wr_data | input | 16 | Write data |
| wr_en | input | 1 | Write enable |
| rd_en | input | 1 | Read enable |
| lane_mask | input | 2 | Per-lane write mask, bit i for byte i |
| addr_hold | input | 1 | Freezes the address register while high |
| rd_data | output | 16 | Registered read data |

## Verification
On every cycle, the assertions check four things: the address register either holds or follows the bus according to `addr_hold`, each lane's output stays put while its read is idle, a written and read lane in new-data mode returns the incoming byte, and reset clears the output. Lane merging against stored contents, the old-data result for masked lanes, the two-edge latency, and the fact that unwritten words are untouched all depend on what the memory held earlier. Only the bench's scenarios can show these, using a reference copy of the array and two instances that differ only in read-during-write mode.

// File: rtl/bytelane_ram_pkg.sv
package bytelane_ram_pkg;
  typedef enum logic {
    RDW_OLD = 1'b0,
    RDW_NEW = 1'b1
  } rdw_mode_e;

  localparam int LANE_W = 8;
endpackage

// File: rtl/blr_addr_reg.sv
module blr_addr_reg #(
  parameter int AW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hold,
  input  logic [AW-1:0] addr_in,
  output logic [AW-1:0] addr_q
);
  always_ff @(posedge clk) begin
    if (rst)        addr_q <= '0;
    else if (!hold) addr_q <= addr_in;
  end

  assert_hold_freezes_R4: assert property (@(posedge clk) disable iff (rst)
    hold |=> $stable(addr_q));
  assert_follows_bus_R4: assert property (@(posedge clk) disable iff (rst)
    !hold |=> (addr_q == $past(addr_in)));
endmodule

// File: rtl/blr_lane.sv
module blr_lane #(
  parameter int DEPTH = 512,
  parameter int AW = $clog2(DEPTH),
  parameter bytelane_ram_pkg::rdw_mode_e RDW_MODE = bytelane_ram_pkg::RDW_NEW
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic [AW-1:0]                       addr,
  input  logic                                wr,
  input  logic                                rd,
  input  logic [bytelane_ram_pkg::LANE_W-1:0] din,
  output logic [bytelane_ram_pkg::LANE_W-1:0] dout
);
  localparam int W = bytelane_ram_pkg::LANE_W;

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr) mem[addr] <= din;
  end

  generate
    if (RDW_MODE == bytelane_ram_pkg::RDW_NEW) begin : g_new
      always_ff @(posedge clk) begin
        if (rst)     dout <= '0;
        else if (rd) dout <= wr ? din : mem[addr];
      end
      assert_new_data_R3: assert property (@(posedge clk) disable iff (rst)
        (wr && rd) |=> (dout == $past(din)));
    end else begin : g_old
      always_ff @(posedge clk) begin
        if (rst)     dout <= '0;
        else if (rd) dout <= mem[addr];
      end
    end
  endgenerate

  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !rd |=> $stable(dout));
endmodule

// File: rtl/bytelane_ram.sv
module bytelane_ram #(
  parameter int DEPTH = 512,
  parameter int DATA_W = 16,
  parameter bytelane_ram_pkg::rdw_mode_e RDW_MODE = bytelane_ram_pkg::RDW_NEW,
  localparam int AW = $clog2(DEPTH),
  localparam int LANES = DATA_W / bytelane_ram_pkg::LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [AW-1:0]     addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [LANES-1:0]  lane_mask,
  input  logic              addr_hold,
  output logic [DATA_W-1:0] rd_data
);
  localparam int W = bytelane_ram_pkg::LANE_W;

  logic [AW-1:0]     addr_q;
  logic [DATA_W-1:0] data_q;
  logic              wr_q;
  logic              rd_q;
  logic [LANES-1:0]  mask_q;

  blr_addr_reg #(.AW(AW)) u_addr (
    .clk    (clk),
    .rst    (rst),
    .hold   (addr_hold),
    .addr_in(addr),
    .addr_q (addr_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q   <= 1'b0;
      rd_q   <= 1'b0;
      mask_q <= '0;
      data_q <= '0;
    end else begin
      wr_q   <= wr_en;
      rd_q   <= rd_en;
      mask_q <= lane_mask;
      data_q <= wr_data;
    end
  end

  genvar i;
  generate
    for (i = 0; i < LANES; i++) begin : g_lane
      blr_lane #(.DEPTH(DEPTH), .AW(AW), .RDW_MODE(RDW_MODE)) u_lane (
        .clk (clk),
        .rst (rst),
        .addr(addr_q),
        .wr  (wr_q && mask_q[i]),
        .rd  (rd_q),
        .din (data_q[i*W +: W]),
        .dout(rd_data[i*W +: W])
      );
    end
  endgenerate

  assert_reset_clears_R8: assert property (@(posedge clk)
    rst |=> (rd_data == '0));
endmodule

// File: tb/tb_bytelane_ram.sv
module tb_bytelane_ram;
  localparam int DEPTH = 512;
  localparam int AW = 9;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [15:0] wr_data = '0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [1:0]  lane_mask = '0;
  logic        addr_hold = 1'b0;
  logic [15:0] dout_new;
  logic [15:0] dout_old;

  always #2.5 clk = ~clk;

  bytelane_ram #(.DEPTH(DEPTH), .DATA_W(16), .RDW_MODE(bytelane_ram_pkg::RDW_NEW)) dut (
    .clk(clk), .rst(rst), .addr(addr), .wr_data(wr_data), .wr_en(wr_en),
    .rd_en(rd_en), .lane_mask(lane_mask), .addr_hold(addr_hold), .rd_data(dout_new));

  bytelane_ram #(.DEPTH(DEPTH), .DATA_W(16), .RDW_MODE(bytelane_ram_pkg::RDW_OLD)) dut_old (
    .clk(clk), .rst(rst), .addr(addr), .wr_data(wr_data), .wr_en(wr_en),
    .rd_en(rd_en), .lane_mask(lane_mask), .addr_hold(addr_hold), .rd_data(dout_old));

  int n_checks = 0;
  int n_fails = 0;
  logic [15:0] ref_mem [DEPTH];
  logic [AW-1:0] held = '0;
  logic [15:0] exp_new = '0;
  logic [15:0] exp_old = '0;
  bit done = 1'b0;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // One access: inputs sampled at edge 1, array acts at edge 2, checked after edge 2.
  task automatic access(input string tag, input logic [AW-1:0] a, input logic [15:0] d,
                        input logic we, input logic re, input logic [1:0] be, input logic st);
    logic [AW-1:0] eff;
    logic [15:0] old_w;
    @(negedge clk);
    addr = a; wr_data = d; wr_en = we; rd_en = re; lane_mask = be; addr_hold = st;
    @(posedge clk);
    @(negedge clk);
    chk({tag, " R7 no change after first edge (new)"}, dout_new, exp_new);
    chk({tag, " R7 no change after first edge (old)"}, dout_old, exp_old);
    wr_en = 1'b0; rd_en = 1'b0;
    eff = st ? held : a;
    held = eff;
    old_w = ref_mem[eff];
    if (re) begin
      for (int i = 0; i < 2; i++) begin
        exp_old[i*8 +: 8] = old_w[i*8 +: 8];
        exp_new[i*8 +: 8] = (we && be[i]) ? d[i*8 +: 8] : old_w[i*8 +: 8];
      end
    end
    if (we)
      for (int i = 0; i < 2; i++)
        if (be[i]) ref_mem[eff][i*8 +: 8] = d[i*8 +: 8];
    @(posedge clk);
    @(negedge clk);
    chk({tag, " (new mode)"}, dout_new, exp_new);
    chk({tag, " (old mode)"}, dout_old, exp_old);
  endtask

  task automatic read_word(input string tag, input logic [AW-1:0] a);
    access(tag, a, 16'h0000, 1'b0, 1'b1, 2'b00, 1'b0);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R8 reset output (new)", dout_new, 16'h0000);
    chk("R8 reset output (old)", dout_old, 16'h0000);
    rst = 1'b0;
  endtask

  task automatic t_fill();
    for (int k = 0; k < 12; k++)
      access("R7 fill", AW'(k), 16'hFFFF, 1'b1, 1'b0, 2'b11, 1'b0);
    read_word("R1 fill readback", 9'd3);
  endtask

  task automatic t_lanes();
    // R1 R2 R3: write while reading, per-lane merge
    access("R2 R3 mask 10 rdw", 9'd0, 16'hABCD, 1'b1, 1'b1, 2'b10, 1'b0);
    access("R2 R3 mask 01 rdw", 9'd1, 16'hABCD, 1'b1, 1'b1, 2'b01, 1'b0);
    access("R3 mask 11 rdw", 9'd2, 16'hABCD, 1'b1, 1'b1, 2'b11, 1'b0);
    read_word("R1 word after mask 10", 9'd0);
    chk("R1 value ABFF", dout_new, 16'hABFF);
    read_word("R1 word after mask 01", 9'd1);
    chk("R1 value FFCD", dout_new, 16'hFFCD);
    read_word("R1 word after mask 11", 9'd2);
    chk("R1 value ABCD", dout_new, 16'hABCD);
    access("R2 R3 overwrite low lane", 9'd2, 16'h1234, 1'b1, 1'b1, 2'b01, 1'b0);
    read_word("R1 merged word", 9'd2);
    chk("R1 value AB34", dout_new, 16'hAB34);
  endtask

  task automatic t_zero_mask();
    access("R9 mask 00 write+read", 9'd4, 16'h5A5A, 1'b1, 1'b1, 2'b00, 1'b0);
    chk("R9 old word returned", dout_new, 16'hFFFF);
    read_word("R9 word unchanged", 9'd4);
    chk("R9 value FFFF", dout_new, 16'hFFFF);
  endtask

  task automatic t_no_write();
    access("R5 wr_en low read", 9'd5, 16'h0F0F, 1'b0, 1'b1, 2'b11, 1'b0);
    read_word("R5 word unchanged", 9'd5);
    chk("R5 value FFFF", dout_new, 16'hFFFF);
  endtask

  task automatic t_no_read();
    read_word("R6 prime", 9'd0);
    access("R6 write with rd_en low", 9'd6, 16'h7777, 1'b1, 1'b0, 2'b11, 1'b0);
    access("R6 idle", 9'd7, 16'h0000, 1'b0, 1'b0, 2'b00, 1'b0);
    chk("R6 output held", dout_new, 16'hABFF);
    read_word("R6 write landed", 9'd6);
  endtask

  task automatic t_hold();
    read_word("R4 set address", 9'd8);
    access("R4 held write", 9'd10, 16'hC0DE, 1'b1, 1'b1, 2'b11, 1'b1);
    access("R4 held write lane", 9'd11, 16'h00EE, 1'b1, 1'b1, 2'b01, 1'b1);
    access("R4 held read", 9'd9, 16'h0000, 1'b0, 1'b1, 2'b00, 1'b1);
    chk("R4 held address value", dout_new, 16'hC0EE);
    read_word("R4 bus word 10 untouched", 9'd10);
    chk("R4 value FFFF", dout_new, 16'hFFFF);
    read_word("R4 word 8 written", 9'd8);
    chk("R4 value C0EE", dout_new, 16'hC0EE);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_fill();
    t_lanes();
    t_zero_mask();
    t_no_write();
    t_no_read();
    t_hold();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule